// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter with a small set of multiplexed analog inputs. It steers the channel multiplexer, opens the sample/hold switch for a fixed number of clock cycles, and then resolves a 10-bit code one bit at a time. For each bit it presents a trial code to an external compare DAC and reads a single comparator bit. Finished codes land in one result register per channel. The analog sample/hold, the DAC and the comparator sit outside the block.

Software sets a run bit, an operating mode, a trigger source and a channel setting. In select mode one channel is converted, either once or over and over. In scan mode channel 0 up to the configured last channel are converted in turn, either for one pass or in repeated passes. The end-of-conversion interrupt follows the mode: in select mode it fires after every conversion, and in scan mode it fires once at the end of each pass. With the software trigger the block starts as soon as the run bit is set. With a hardware trigger it first waits armed for a pulse on the chosen trigger line.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset every result register reads 0, and `eoc_irq`, `sh_sample` and `dac_code` are all 0.
- R2: Each conversion holds `sh_sample` high for exactly SAMPLE_CYC cycles. During that time `dac_code` is 0 and `ch_sel` does not change. The bit trials follow, each taking one DAC settling cycle and one comparator cycle.
- R3: Bits are tried from bit 9 down to bit 0. A trial bit is kept when `cmp_hi` is 1 (input at or above `dac_code`) and cleared otherwise, so the stored code is the largest code not above the input. The result and `eoc_irq` appear 2*NBITS+1 cycles after `sh_sample` falls.
- R4: A finished code is written only into the result slice of the channel just converted (`results[ch*NBITS +: NBITS]`). All other slices keep their values.
- R5: In one-shot select mode (`op_mode`=2'b00) with the software trigger, exactly one conversion runs. No further sampling happens until `enable` is cleared and set again.
- R6: In continuous select mode (`op_mode`=2'b10) the same channel is converted again and again, with one interrupt per conversion, until `enable` is cleared.
- R7: In one-shot scan mode (`op_mode`=2'b01) channels 0 through the last channel are converted once, in ascending order, and exactly one interrupt is raised after the last channel.
- R8: In continuous scan mode (`op_mode`=2'b11) the pass restarts at channel 0 after the last channel, with one interrupt per pass.
- R9: With `trig_sel`=2'b01 (external line) or `trig_sel`=2'b1x (timer line), setting `enable` arms the block without sampling. A one-cycle pulse on the selected line starts a conversion or a pass, and the other line is ignored. A hardware one-shot run returns to the armed state.
- R10: A hardware trigger pulse that arrives while a conversion or pass is in progress starts nothing extra.
- R11: Clearing `enable` during a run stops it on the next clock edge: `sh_sample` and `dac_code` return to 0, no interrupt is raised and no result register changes.
- R12: A `last_cfg` value of NCH or more is treated as NCH-1, both for the scan end and for the select channel.
- R13: `eoc_irq` is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run bit; clearing it aborts |
| trig_sel | input | 2 | 00 software, 01 external line, 1x timer line |
| ext_trig | input | 1 | External trigger pulse |
| tmr_trig | input | 1 | Timer trigger pulse |
| op_mode | input | 2 | bit0: 1 scan / 0 select; bit1: 1 continuous / 0 one-shot |
| last_cfg | input | CFG_W | Select channel, or last channel of a scan |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| sh_sample | output | 1 | Sample/hold switch closed (sampling) |
| dac_code | output | NBITS | Trial code to the compare DAC |
| ch_sel | output | CH_W | Analog multiplexer channel |
| results | output | NCH*NBITS | Per-channel result registers, channel 0 in the low bits |
| eoc_irq | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
The bench puts an ideal comparator behind the DAC and sweeps all 1024 input codes. A wrong keep/clear rule or a wrong trial order would leave off-by-one or bit-flipped codes near the major transitions. It counts sample cycles and trial latency, so a stray settle cycle or a missing one shows up as a wrong count. It records the channel order and the interrupt count for one-shot scans, continuous scans and a clamped last channel, which catches scans that skip a channel, run past the last one or raise an interrupt per channel. Stray trigger pulses on the unselected line and during a run, and an abort in the middle of the trials, check that the block neither starts twice nor corrupts a stored result.

// File: rtl/sar_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sar_seq_pkg;

    // Channel/mode controller states.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_RUN   = 2'd2,
        SQ_HALT  = 2'd3
    } seq_state_e;

    // Bit-trial engine states.
    typedef enum logic [1:0] {
        EN_IDLE   = 2'd0,
        EN_SAMPLE = 2'd1,
        EN_SETTLE = 2'd2,
        EN_CMP    = 2'd3
    } eng_state_e;

    localparam logic [1:0] TRIG_SW  = 2'b00;
    localparam logic [1:0] TRIG_EXT = 2'b01;

endpackage

// File: rtl/sar_bit_engine.sv
// Bit-trial engine: samples for SAMPLE_CYC cycles, then resolves NBITS
// bits MSB first, two cycles per bit (DAC settle, comparator read).
// Assumes: start is a one-cycle pulse accepted only when idle; abort
// has priority over everything and returns the engine to idle.
module sar_bit_engine
    import sar_seq_pkg::*;
#(
    parameter int NBITS      = 10,
    parameter int SAMPLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic             cmp_hi,
    output logic             sh_sample,
    output logic [NBITS-1:0] dac_code,
    output logic             done,
    output logic [NBITS-1:0] code
);

    localparam int CNT_W = $clog2(SAMPLE_CYC + 1);
    localparam int BIT_W = (NBITS > 1) ? $clog2(NBITS) : 1;

    eng_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bit_idx;
    logic [NBITS-1:0] work;
    logic [NBITS-1:0] mask;
    logic [NBITS-1:0] work_next;

    // Trial mask and the working value after this cycle's comparison.
    always_comb begin
        mask      = {{(NBITS-1){1'b0}}, 1'b1} << bit_idx;
        work_next = cmp_hi ? (work | mask) : work;
    end

    // Outputs to the analog front end.
    always_comb begin
        sh_sample = (state == EN_SAMPLE);
        dac_code  = ((state == EN_SETTLE) || (state == EN_CMP)) ? (work | mask) : '0;
    end

    // Sampling and bit-trial sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= EN_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            work    <= '0;
            done    <= 1'b0;
            code    <= '0;
        end else if (abort) begin
            state   <= EN_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            work    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                EN_IDLE: begin
                    if (start) begin
                        state   <= EN_SAMPLE;
                        cnt     <= '0;
                        work    <= '0;
                        bit_idx <= '0;
                    end
                end
                EN_SAMPLE: begin
                    if (cnt == CNT_W'(SAMPLE_CYC - 1)) begin
                        state   <= EN_SETTLE;
                        bit_idx <= BIT_W'(NBITS - 1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                EN_SETTLE: begin
                    state <= EN_CMP;
                end
                EN_CMP: begin
                    work <= work_next;
                    if (bit_idx == '0) begin
                        state <= EN_IDLE;
                        done  <= 1'b1;
                        code  <= work_next;
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                        state   <= EN_SETTLE;
                    end
                end
                default: state <= EN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_ch_sequencer.sv
// Channel and mode controller: handles triggering, select/scan order,
// one-shot/continuous repetition and interrupt timing.
// Assumes: the engine reports done one cycle after its last trial, and
// configuration is latched when a run or pass starts.
module sar_ch_sequencer
    import sar_seq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CFG_W = 4,
    parameter int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [1:0]      trig_sel,
    input  logic            ext_trig,
    input  logic            tmr_trig,
    input  logic [1:0]      op_mode,
    input  logic [CFG_W-1:0] last_cfg,
    input  logic            eng_done,
    output logic            launch,
    output logic [CH_W-1:0] ch,
    output logic            irq,
    output logic            wr_en
);

    seq_state_e      state;
    logic            scan_q;
    logic            cont_q;
    logic [CH_W-1:0] last_q;
    logic [CH_W-1:0] last_eff;
    logic            hw_mode;
    logic            trig_hit;

    // Clamp the channel setting to the implemented channels.
    always_comb begin
        if (int'(last_cfg) >= NCH) last_eff = CH_W'(NCH - 1);
        else                       last_eff = CH_W'(last_cfg);
    end

    // Trigger source decode.
    always_comb begin
        hw_mode  = (trig_sel != TRIG_SW);
        trig_hit = (trig_sel == TRIG_EXT) ? ext_trig : (trig_sel[1] & tmr_trig);
    end

    // Result write strobe: only for a conversion that was not aborted.
    assign wr_en = eng_done && enable && (state == SQ_RUN);

    // Run control and channel stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            scan_q <= 1'b0;
            cont_q <= 1'b0;
            last_q <= '0;
            ch     <= '0;
            launch <= 1'b0;
            irq    <= 1'b0;
        end else begin
            launch <= 1'b0;
            irq    <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (enable) begin
                        scan_q <= op_mode[0];
                        cont_q <= op_mode[1];
                        last_q <= last_eff;
                        ch     <= op_mode[0] ? '0 : last_eff;
                        if (hw_mode) begin
                            state <= SQ_ARMED;
                        end else begin
                            state  <= SQ_RUN;
                            launch <= 1'b1;
                        end
                    end
                end
                SQ_ARMED: begin
                    if (!enable) begin
                        state <= SQ_IDLE;
                    end else if (trig_hit) begin
                        scan_q <= op_mode[0];
                        cont_q <= op_mode[1];
                        last_q <= last_eff;
                        ch     <= op_mode[0] ? '0 : last_eff;
                        state  <= SQ_RUN;
                        launch <= 1'b1;
                    end
                end
                SQ_RUN: begin
                    if (!enable) begin
                        state <= SQ_IDLE;
                    end else if (eng_done) begin
                        if (!scan_q) begin
                            irq <= 1'b1;
                            if (cont_q) launch <= 1'b1;
                            else        state  <= hw_mode ? SQ_ARMED : SQ_HALT;
                        end else if (ch == last_q) begin
                            irq <= 1'b1;
                            if (cont_q) begin
                                ch     <= '0;
                                launch <= 1'b1;
                            end else begin
                                state <= hw_mode ? SQ_ARMED : SQ_HALT;
                            end
                        end else begin
                            ch     <= ch + 1'b1;
                            launch <= 1'b1;
                        end
                    end
                end
                SQ_HALT: begin
                    if (!enable) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_result_bank.sv
// Per-channel result registers, written by a one-cycle strobe.
// Assumes: wr_ch is below NCH whenever wr_en is high.
module sar_result_bank #(
    parameter int NBITS = 10,
    parameter int NCH   = 4,
    parameter int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CH_W-1:0]      wr_ch,
    input  logic [NBITS-1:0]     wr_code,
    output logic [NCH*NBITS-1:0] results
);

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic [NBITS-1:0] slot_q;

        // Capture the finished code for this channel only.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 slot_q <= '0;
            else if (wr_en && (wr_ch == CH_W'(g)))      slot_q <= wr_code;
        end

        assign results[g*NBITS +: NBITS] = slot_q;
    end

endmodule

// File: rtl/sar_conv_seq.sv
// Top of the conversion sequencer: joins the channel controller, the
// bit-trial engine and the result bank. Clearing enable aborts at once.
// Assumes: the comparator output reflects dac_code in the same cycle.
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int NBITS      = 10,
    parameter int NCH        = 4,
    parameter int SAMPLE_CYC = 4,
    parameter int CFG_W      = 4,
    parameter int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [1:0]           trig_sel,
    input  logic                 ext_trig,
    input  logic                 tmr_trig,
    input  logic [1:0]           op_mode,
    input  logic [CFG_W-1:0]     last_cfg,
    input  logic                 cmp_hi,
    output logic                 sh_sample,
    output logic [NBITS-1:0]     dac_code,
    output logic [CH_W-1:0]      ch_sel,
    output logic [NCH*NBITS-1:0] results,
    output logic                 eoc_irq
);

    logic             launch;
    logic             eng_done;
    logic [NBITS-1:0] eng_code;
    logic             wr_en;

    sar_ch_sequencer #(.NCH(NCH), .CFG_W(CFG_W), .CH_W(CH_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .trig_sel (trig_sel),
        .ext_trig (ext_trig),
        .tmr_trig (tmr_trig),
        .op_mode  (op_mode),
        .last_cfg (last_cfg),
        .eng_done (eng_done),
        .launch   (launch),
        .ch       (ch_sel),
        .irq      (eoc_irq),
        .wr_en    (wr_en)
    );

    sar_bit_engine #(.NBITS(NBITS), .SAMPLE_CYC(SAMPLE_CYC)) i_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!enable),
        .start     (launch),
        .cmp_hi    (cmp_hi),
        .sh_sample (sh_sample),
        .dac_code  (dac_code),
        .done      (eng_done),
        .code      (eng_code)
    );

    sar_result_bank #(.NBITS(NBITS), .NCH(NCH), .CH_W(CH_W)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (ch_sel),
        .wr_code (eng_code),
        .results (results)
    );

endmodule

// File: rtl/sar_conv_seq_chk.sv
// Property checker for sar_conv_seq, attached with bind below.
// Assumes the same parameters as the bound instance.
module sar_conv_seq_chk #(
    parameter int NBITS      = 10,
    parameter int NCH        = 4,
    parameter int SAMPLE_CYC = 4,
    parameter int CH_W       = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic                 sh_sample,
    input logic [NBITS-1:0]     dac_code,
    input logic [CH_W-1:0]      ch_sel,
    input logic [NCH*NBITS-1:0] results,
    input logic                 eoc_irq
);

    logic [15:0] run_len;

    // Length of the current sampling window so far.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_len <= '0;
        else if (sh_sample) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    p_sample_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_sample |-> (int'(run_len) < SAMPLE_CYC));

    p_sample_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sh_sample) && $past(enable)) |-> (int'(run_len) == SAMPLE_CYC));

    p_dac_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_sample |-> (dac_code == '0));

    p_chsel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_sample && $past(sh_sample)) |-> $stable(ch_sel));

    p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sh_sample && (dac_code == '0) && !eoc_irq));

    p_abort_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(results));

    p_irq_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
    .NBITS(NBITS), .NCH(NCH), .SAMPLE_CYC(SAMPLE_CYC), .CH_W(CH_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sh_sample (sh_sample),
    .dac_code  (dac_code),
    .ch_sel    (ch_sel),
    .results   (results),
    .eoc_irq   (eoc_irq)
);

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;

    localparam int NBITS = 10;
    localparam int NCH   = 4;
    localparam int SCYC  = 4;
    localparam int CFG_W = 4;
    localparam int CH_W  = 2;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 enable;
    logic [1:0]           trig_sel;
    logic                 ext_trig;
    logic                 tmr_trig;
    logic [1:0]           op_mode;
    logic [CFG_W-1:0]     last_cfg;
    logic                 cmp_hi;
    logic                 sh_sample;
    logic [NBITS-1:0]     dac_code;
    logic [CH_W-1:0]      ch_sel;
    logic [NCH*NBITS-1:0] results;
    logic                 eoc_irq;

    logic [NBITS-1:0] vin [NCH];

    int total = 0;
    int bad   = 0;
    int starts = 0;
    int irqs   = 0;
    int cycles = 0;
    logic [CH_W-1:0] order [64];
    logic prev_sh = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    // Ideal comparator behind the DAC.
    assign cmp_hi = (vin[ch_sel] >= dac_code);

    sar_conv_seq #(.NBITS(NBITS), .NCH(NCH), .SAMPLE_CYC(SCYC), .CFG_W(CFG_W)) i_sar_conv_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig_sel(trig_sel),
        .ext_trig(ext_trig), .tmr_trig(tmr_trig), .op_mode(op_mode),
        .last_cfg(last_cfg), .cmp_hi(cmp_hi), .sh_sample(sh_sample),
        .dac_code(dac_code), .ch_sel(ch_sel), .results(results), .eoc_irq(eoc_irq)
    );

    // Monitor: counts sampling starts (with channel) and interrupts.
    always @(posedge clk) begin
        if (rst_n) begin
            if (sh_sample && !prev_sh) begin
                order[starts % 64] = ch_sel;
                starts = starts + 1;
            end
            if (eoc_irq) irqs = irqs + 1;
        end
        prev_sh = sh_sample;
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int res(input int ch);
        return int'(results[ch*NBITS +: NBITS]);
    endfunction

    task automatic wait_irq(input int lim, input string req);
        int cyc = 0;
        while (!eoc_irq && cyc < lim) begin
            tick();
            cyc++;
        end
        check(eoc_irq == 1'b1, req, cyc, lim);
    endtask

    task automatic pulse_ext();
        ext_trig = 1'b1; tick(); ext_trig = 1'b0;
    endtask

    task automatic pulse_tmr();
        tmr_trig = 1'b1; tick(); tmr_trig = 1'b0;
    endtask

    initial begin
        int bs, bi, cnt, hc;
        logic [NBITS-1:0] v;
        rst_n = 1'b0; enable = 1'b0; trig_sel = 2'b00; ext_trig = 1'b0;
        tmr_trig = 1'b0; op_mode = 2'b00; last_cfg = '0;
        vin[0] = 10'd100; vin[1] = 10'd200; vin[2] = 10'd300; vin[3] = 10'd400;
        repeat (5) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check(results == '0, "R1 results", int'(results[NBITS-1:0]), 0);
        check(!eoc_irq && !sh_sample && dac_code == '0, "R1 outputs", int'(dac_code), 0);

        // R2/R3/R4: single software conversion on channel 2
        vin[2] = 10'h2A7; last_cfg = 4'd2; op_mode = 2'b00; enable = 1'b1;
        cnt = 0;
        while (!sh_sample && cnt < 20) begin tick(); cnt++; end
        hc = 0;
        while (sh_sample && hc < 50) begin hc++; tick(); end
        check(hc == SCYC, "R2 sample length", hc, SCYC);
        cnt = 0;
        while (!eoc_irq && cnt < 100) begin tick(); cnt++; end
        check(cnt == 2*NBITS + 1, "R3 trial latency", cnt, 2*NBITS + 1);
        check(res(2) == 'h2A7, "R3 code ch2", res(2), 'h2A7);
        check(res(0) == 0 && res(1) == 0 && res(3) == 0, "R4 other slots", res(0) + res(1) + res(3), 0);
        tick();
        check(!eoc_irq, "R13 irq width", int'(eoc_irq), 0);

        // R5: one-shot select stops
        bs = starts; bi = irqs;
        repeat (60) tick();
        check(starts == bs && irqs == bi, "R5 no restart", starts - bs, 0);
        enable = 1'b0; tick(); tick();

        // R3: exhaustive code sweep on channel 1
        last_cfg = 4'd1;
        for (int c = 0; c < (1 << NBITS); c++) begin
            vin[1] = NBITS'(c);
            enable = 1'b1;
            wait_irq(80, "R3 sweep irq");
            check(res(1) == c, "R3 sweep code", res(1), c);
            enable = 1'b0;
            tick();
        end
        tick();

        // R6: continuous select on channel 0
        last_cfg = 4'd0; op_mode = 2'b10; vin[0] = 10'h155;
        bi = irqs;
        enable = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wait_irq(80, "R6 repeat irq");
            check(res(0) == int'(vin[0]), "R6 repeat code", res(0), int'(vin[0]));
            vin[0] = vin[0] + 10'h061;
            tick();
        end
        enable = 1'b0; tick();
        repeat (3) tick();
        check(irqs - bi == 4, "R6 irq per conversion", irqs - bi, 4);
        bs = starts; bi = irqs;
        repeat (60) tick();
        check(starts == bs && irqs == bi, "R6 stop on clear", starts - bs, 0);

        // R7: one-shot scan of 0..3
        vin[0] = 10'h011; vin[1] = 10'h3F0; vin[2] = 10'h200; vin[3] = 10'h1FF;
        op_mode = 2'b01; last_cfg = 4'd3;
        bs = starts; bi = irqs;
        enable = 1'b1;
        wait_irq(300, "R7 scan irq");
        repeat (80) tick();
        check(irqs - bi == 1, "R7 single irq", irqs - bi, 1);
        check(starts - bs == 4, "R7 channel count", starts - bs, 4);
        for (int k = 0; k < 4; k++) begin
            check(int'(order[(bs + k) % 64]) == k, "R7 order", int'(order[(bs + k) % 64]), k);
            check(res(k) == int'(vin[k]), "R7 code", res(k), int'(vin[k]));
        end
        enable = 1'b0; tick(); tick();

        // R12: clamp of an oversize last channel in scan and select
        vin[0] = 10'h001; vin[1] = 10'h002; vin[2] = 10'h003; vin[3] = 10'h3FE;
        last_cfg = 4'd9;
        bs = starts; bi = irqs;
        enable = 1'b1;
        wait_irq(300, "R12 scan irq");
        repeat (80) tick();
        check(starts - bs == 4 && irqs - bi == 1, "R12 scan clamp", starts - bs, 4);
        check(int'(order[(bs + 3) % 64]) == 3, "R12 last ch", int'(order[(bs + 3) % 64]), 3);
        check(res(3) == 'h3FE, "R12 scan code", res(3), 'h3FE);
        enable = 1'b0; tick(); tick();
        op_mode = 2'b00; last_cfg = 4'd12; vin[3] = 10'h0C3;
        bs = starts;
        enable = 1'b1;
        wait_irq(80, "R12 select irq");
        check(int'(order[bs % 64]) == 3, "R12 select ch", int'(order[bs % 64]), 3);
        check(res(3) == 'h0C3, "R12 select code", res(3), 'h0C3);
        enable = 1'b0; tick(); tick();

        // R8: continuous scan of 0..1
        op_mode = 2'b11; last_cfg = 4'd1; vin[0] = 10'h123; vin[1] = 10'h321;
        bs = starts; bi = irqs;
        enable = 1'b1;
        wait_irq(120, "R8 pass1 irq");
        tick();
        wait_irq(120, "R8 pass2 irq");
        enable = 1'b0;
        repeat (40) tick();
        check(irqs - bi == 2, "R8 irq per pass", irqs - bi, 2);
        check(starts - bs == 4, "R8 conversions", starts - bs, 4);
        for (int k = 0; k < 4; k++)
            check(int'(order[(bs + k) % 64]) == (k % 2), "R8 order", int'(order[(bs + k) % 64]), k % 2);
        check(res(0) == 'h123 && res(1) == 'h321, "R8 codes", res(1), 'h321);

        // R9: external trigger, timer line ignored
        op_mode = 2'b00; last_cfg = 4'd2; trig_sel = 2'b01; vin[2] = 10'h3A5;
        bs = starts;
        enable = 1'b1;
        repeat (40) tick();
        check(starts == bs, "R9 armed no sample", starts - bs, 0);
        pulse_tmr();
        repeat (40) tick();
        check(starts == bs, "R9 wrong line ignored", starts - bs, 0);
        pulse_ext();
        wait_irq(80, "R9 ext irq");
        check(res(2) == 'h3A5, "R9 ext code", res(2), 'h3A5);
        vin[2] = 10'h05A;
        repeat (10) tick();
        pulse_ext();
        wait_irq(80, "R9 rearm irq");
        check(res(2) == 'h05A, "R9 rearm code", res(2), 'h05A);
        // timer line selected while armed
        trig_sel = 2'b10; vin[2] = 10'h2E1;
        repeat (5) tick();
        bs = starts;
        pulse_ext();
        repeat (40) tick();
        check(starts == bs, "R9 ext ignored in timer", starts - bs, 0);
        pulse_tmr();
        wait_irq(80, "R9 tmr irq");
        check(res(2) == 'h2E1, "R9 tmr code", res(2), 'h2E1);
        repeat (5) tick();

        // R10: triggers during a run are ignored
        trig_sel = 2'b01; vin[2] = 10'h111;
        bs = starts; bi = irqs;
        pulse_ext();
        repeat (3) tick();
        pulse_ext();
        repeat (12) tick();
        pulse_ext();
        wait_irq(80, "R10 irq");
        repeat (40) tick();
        check(starts - bs == 1 && irqs - bi == 1, "R10 one conversion", starts - bs, 1);
        enable = 1'b0; trig_sel = 2'b00; tick(); tick();

        // R11: abort during bit trials and during sampling
        last_cfg = 4'd1; vin[1] = 10'h2C2;
        enable = 1'b1;
        wait_irq(80, "R11 setup irq");
        enable = 1'b0; tick(); tick();
        vin[1] = 10'h0F0;
        bi = irqs;
        enable = 1'b1;
        cnt = 0;
        while (!sh_sample && cnt < 20) begin tick(); cnt++; end
        while (sh_sample && cnt < 40) begin tick(); cnt++; end
        repeat (6) tick();
        enable = 1'b0;
        tick();
        check(!sh_sample && dac_code == '0, "R11 idle after abort", int'(dac_code), 0);
        repeat (40) tick();
        check(irqs == bi, "R11 no irq", irqs - bi, 0);
        check(res(1) == 'h2C2, "R11 result kept", res(1), 'h2C2);
        enable = 1'b1;
        cnt = 0;
        while (!sh_sample && cnt < 20) begin tick(); cnt++; end
        tick();
        enable = 1'b0;
        tick();
        check(!sh_sample, "R11 abort in sampling", int'(sh_sample), 0);
        repeat (40) tick();
        check(res(1) == 'h2C2 && irqs == bi, "R11 sampling abort kept", res(1), 'h2C2);

        summary();
        $finish;
    end

endmodule